// File: doc/BRIEF.md
# Pixel event frame packer

The block turns the readout of one pixel chip event into a stream of framed 32-bit words. An upstream sequencer sends it one command at a time over a single valid/ready input channel. The commands are: open an event, carrying its metadata; deliver one pixel hit, carrying an address, an ADC value and a flag; and close the event. The block answers with a header word, one hit word for each accepted hit in arrival order, and a trailer word. The trailer holds the hit count, a 12-bit folded XOR checksum over the hit words, and four sticky error flags.

Each output word is tagged with its kind, so a downstream serialiser can see frame boundaries without decoding the payload. Every command produces at most one output word, and one output register separates the two sides. When the consumer stalls, the input channel is stalled too, so no word is lost and no word is duplicated. Commands that break the framing rules are absorbed: a hit with no open event, a close with no open event, or an open while an event is already open. Each of these is reported in the error flags of the next trailer.

Top module: `evframe_packer`

## Requirements
- R1: A start command (in_op=01) accepted by the block emits a header word tagged out_kind=01 with bunch-crossing id in [31:20], event id in [19:12], chip address in [11:8] and status in [7:0].
- R2: A hit command (in_op=10) accepted while an event is open emits a word tagged out_kind=10, laid out as {2'b00, address[23:0], adc[4:0], flag}, with the address in [29:6], the ADC value in [5:1] and the flag in bit 0.
- R3: An end command (in_op=11) accepted while an event is open emits a trailer tagged out_kind=11. The trailer holds the hit count in [31:16], the checksum in [15:4] and the error flags in [3:0]. The checksum is formed as follows: X is the XOR of all 30-bit hit words of the event, and the checksum is X[11:0] ^ X[23:12] ^ {6'b0, X[29:24]}.
- R4: Output words appear strictly in the order header, hits in input order, trailer. A hit or trailer word never follows a trailer without a new header in between, and in_op=00 is consumed with no output.
- R5: An event with no hits produces a header followed directly by a trailer whose count and checksum fields are zero.
- R6: A hit accepted while no event is open produces no output word. It sets error flag bit 0 in the next trailer that is emitted.
- R7: While out_valid is high and out_ready is low, out_data and out_kind hold their values, out_valid stays high and in_ready is low. Every emitted word is delivered exactly once.
- R8: The hit counter saturates at 2^CNT_W-1. Hits beyond that limit are still emitted and still enter the checksum, and they set error flag bit 1 in that event's trailer.
- R9: A start accepted while an event is open abandons that event without a trailer. It emits the new header and sets error flag bit 2 in the next trailer. Counter, checksum and bit 1 restart for the new event.
- R10: An end accepted while no event is open produces no output word. It sets error flag bit 3 in the next trailer that is emitted.
- R11: After reset, out_valid is low, in_ready is high and no event is open.
- R12: All error flags clear once a trailer is emitted, so the next event starts with flags 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input command valid |
| in_ready | output | 1 | Input command accepted when high together with in_valid |
| in_op | input | 2 | Command: 00 none, 01 start, 10 hit, 11 end |
| in_bx | input | 12 | Bunch-crossing id for a start command |
| in_evt | input | 8 | Event id for a start command |
| in_chip | input | 4 | Chip address for a start command |
| in_status | input | 8 | Header status bits for a start command |
| in_addr | input | 24 | Pixel address for a hit command |
| in_adc | input | 5 | ADC value for a hit command |
| in_flag | input | 1 | Per-hit flag for a hit command |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 32 | Output word |
| out_kind | output | 2 | Word kind: 01 header, 10 hit, 11 trailer |

## Verification
The bench builds the packer with CNT_W=4, so the counter saturates after 15 hits. An event of 17 hits therefore reaches the saturation flag and the clipped count field within a few dozen cycles; the default width of 16 would need 65,536 hits to get there. The consumer alternates between always ready and a pseudo-random stall pattern, so words are held in the output register while commands wait. The misuse cases are driven in between well-formed events, and the flag bits they set are read from the next trailer: a hit straight after reset, a stray end, and a reopened event.

// File: rtl/evf_pkg.sv
package evf_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_START = 2'b01,
    OP_HIT   = 2'b10,
    OP_END   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    K_NONE  = 2'b00,
    K_HEAD  = 2'b01,
    K_HIT   = 2'b10,
    K_TRAIL = 2'b11
  } kind_e;

  localparam int WORD_W = 32;
  localparam int HIT_W  = 30;
  localparam int SIZE_W = 16;
  localparam int CSUM_W = 12;
  localparam int ERR_W  = 4;
  localparam int FOLD_HI_W = HIT_W - 2 * CSUM_W;

  localparam int ERR_ORPHAN = 0;
  localparam int ERR_SAT    = 1;
  localparam int ERR_REOPEN = 2;
  localparam int ERR_STRAY  = 3;

  function automatic logic [WORD_W-1:0] make_header(
    input logic [11:0] bx,
    input logic [7:0]  evt,
    input logic [3:0]  chip,
    input logic [7:0]  status
  );
    return {bx, evt, chip, status};
  endfunction

  function automatic logic [HIT_W-1:0] make_hit(
    input logic [23:0] addr,
    input logic [4:0]  adc,
    input logic        flag
  );
    return {addr, adc, flag};
  endfunction

  function automatic logic [CSUM_W-1:0] fold_csum(input logic [HIT_W-1:0] x);
    logic [CSUM_W-1:0] lo, mid, hi;
    lo  = x[CSUM_W-1:0];
    mid = x[2*CSUM_W-1:CSUM_W];
    hi  = {{(CSUM_W-FOLD_HI_W){1'b0}}, x[HIT_W-1:2*CSUM_W]};
    return lo ^ mid ^ hi;
  endfunction

  function automatic logic [WORD_W-1:0] make_trailer(
    input logic [SIZE_W-1:0] size,
    input logic [CSUM_W-1:0] csum,
    input logic [ERR_W-1:0]  err
  );
    return {size, csum, err};
  endfunction

endpackage

// File: rtl/evf_tracker.sv
module evf_tracker
  import evf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  op_e                 op,
  input  logic [HIT_W-1:0]    hit_word,
  output logic                evt_open,
  output logic [CNT_W-1:0]    hit_cnt,
  output logic [HIT_W-1:0]    csum_acc,
  output logic [ERR_W-1:0]    err_q,
  output logic                emit_head,
  output logic                emit_hit,
  output logic                emit_trail,
  output logic                orphan_drop,
  output logic                stray_end,
  output logic                reopen,
  output logic                sat_hit
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic is_start, is_hit, is_end;

  assign is_start = accept && (op == OP_START);
  assign is_hit   = accept && (op == OP_HIT);
  assign is_end   = accept && (op == OP_END);

  assign emit_head   = is_start;
  assign emit_hit    = is_hit && evt_open;
  assign emit_trail  = is_end && evt_open;
  assign orphan_drop = is_hit && !evt_open;
  assign stray_end   = is_end && !evt_open;
  assign reopen      = is_start && evt_open;
  assign sat_hit     = emit_hit && (hit_cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_open <= 1'b0;
      hit_cnt  <= '0;
      csum_acc <= '0;
      err_q    <= '0;
    end else begin
      if (emit_head) begin
        evt_open            <= 1'b1;
        hit_cnt             <= '0;
        csum_acc            <= '0;
        err_q[ERR_SAT]      <= 1'b0;
        err_q[ERR_REOPEN]   <= err_q[ERR_REOPEN] | reopen;
      end
      if (emit_hit) begin
        csum_acc <= csum_acc ^ hit_word;
        if (sat_hit) err_q[ERR_SAT] <= 1'b1;
        else         hit_cnt <= hit_cnt + 1'b1;
      end
      if (orphan_drop) err_q[ERR_ORPHAN] <= 1'b1;
      if (stray_end)   err_q[ERR_STRAY]  <= 1'b1;
      if (emit_trail) begin
        evt_open <= 1'b0;
        hit_cnt  <= '0;
        csum_acc <= '0;
        err_q    <= '0;
      end
    end
  end

endmodule

// File: rtl/evf_formatter.sv
module evf_formatter
  import evf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              emit_head,
  input  logic              emit_hit,
  input  logic              emit_trail,
  input  logic [11:0]       bx,
  input  logic [7:0]        evt,
  input  logic [3:0]        chip,
  input  logic [7:0]        status,
  input  logic [HIT_W-1:0]  hit_word,
  input  logic [CNT_W-1:0]  hit_cnt,
  input  logic [HIT_W-1:0]  csum_acc,
  input  logic [ERR_W-1:0]  err_q,
  output logic              emit_any,
  output logic [WORD_W-1:0] word,
  output kind_e             kind
);

  logic [SIZE_W-1:0] size_ext;

  assign size_ext = SIZE_W'(hit_cnt);
  assign emit_any = emit_head | emit_hit | emit_trail;

  always_comb begin
    word = '0;
    kind = K_NONE;
    if (emit_head) begin
      word = make_header(bx, evt, chip, status);
      kind = K_HEAD;
    end else if (emit_hit) begin
      word = {{(WORD_W-HIT_W){1'b0}}, hit_word};
      kind = K_HIT;
    end else if (emit_trail) begin
      word = make_trailer(size_ext, fold_csum(csum_acc), err_q);
      kind = K_TRAIL;
    end
  end

endmodule

// File: rtl/evf_outreg.sv
module evf_outreg
  import evf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d_word,
  input  kind_e             d_kind,
  input  logic              out_ready,
  output logic              free,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output kind_e             out_kind
);

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_kind  <= K_NONE;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_word;
      out_kind  <= d_kind;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/evframe_packer.sv
module evframe_packer
  import evf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_op,
  input  logic [11:0] in_bx,
  input  logic [7:0]  in_evt,
  input  logic [3:0]  in_chip,
  input  logic [7:0]  in_status,
  input  logic [23:0] in_addr,
  input  logic [4:0]  in_adc,
  input  logic        in_flag,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic [1:0]  out_kind
);

  logic              accept;
  logic [HIT_W-1:0]  hit_word;
  logic              evt_open;
  logic [CNT_W-1:0]  hit_cnt;
  logic [HIT_W-1:0]  csum_acc;
  logic [ERR_W-1:0]  err_q;
  logic              emit_head, emit_hit, emit_trail, emit_any;
  logic              orphan_drop, stray_end, reopen, sat_hit;
  logic [WORD_W-1:0] new_word;
  kind_e             new_kind;
  kind_e             reg_kind;

  assign accept   = in_valid && in_ready;
  assign hit_word = make_hit(in_addr, in_adc, in_flag);
  assign out_kind = reg_kind;

  evf_tracker #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .op         (op_e'(in_op)),
    .hit_word   (hit_word),
    .evt_open   (evt_open),
    .hit_cnt    (hit_cnt),
    .csum_acc   (csum_acc),
    .err_q      (err_q),
    .emit_head  (emit_head),
    .emit_hit   (emit_hit),
    .emit_trail (emit_trail),
    .orphan_drop(orphan_drop),
    .stray_end  (stray_end),
    .reopen     (reopen),
    .sat_hit    (sat_hit)
  );

  evf_formatter #(.CNT_W(CNT_W)) u_fmt (
    .emit_head (emit_head),
    .emit_hit  (emit_hit),
    .emit_trail(emit_trail),
    .bx        (in_bx),
    .evt       (in_evt),
    .chip      (in_chip),
    .status    (in_status),
    .hit_word  (hit_word),
    .hit_cnt   (hit_cnt),
    .csum_acc  (csum_acc),
    .err_q     (err_q),
    .emit_any  (emit_any),
    .word      (new_word),
    .kind      (new_kind)
  );

  evf_outreg u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (emit_any),
    .d_word   (new_word),
    .d_kind   (new_kind),
    .out_ready(out_ready),
    .free     (in_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_kind (reg_kind)
  );

endmodule

// File: rtl/evf_checker.sv
module evf_checker #(
  parameter int CNT_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic [1:0]  out_kind,
  input logic        orphan_drop,
  input logic        stray_end,
  input logic        evt_open,
  input logic        sat_hit
);

  localparam logic [1:0] KH = 2'b01;
  localparam logic [1:0] KD = 2'b10;
  localparam logic [1:0] KT = 2'b11;
  localparam logic [CNT_W-1:0] SEEN_MAX = {CNT_W{1'b1}};

  logic             fire;
  logic [1:0]       last_kind;
  logic [CNT_W-1:0] hits_seen;
  logic             over_seen;

  assign fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= KT;
      hits_seen <= '0;
      over_seen <= 1'b0;
    end else if (fire) begin
      last_kind <= out_kind;
      if (out_kind == KH) begin
        hits_seen <= '0;
        over_seen <= 1'b0;
      end else if (out_kind == KD) begin
        if (hits_seen == SEEN_MAX) over_seen <= 1'b1;
        else                       hits_seen <= hits_seen + 1'b1;
      end
    end
  end

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_kind));

  // R7
  p_stall_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R4
  p_order_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_kind == KD |-> last_kind == KH || last_kind == KD);

  // R4
  p_order_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_kind == KT |-> last_kind == KH || last_kind == KD);

  // R4
  p_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_kind != 2'b00);

  // R2
  p_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KD |-> out_data[31:30] == 2'b00);

  // R3
  p_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_kind == KT |-> out_data[31:16] == 16'(hits_seen));

  // R5
  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_kind == KT && last_kind == KH |-> out_data[31:4] == 28'd0);

  // R8
  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_kind == KT && over_seen |-> out_data[1]);

  // R8
  p_sat_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |-> evt_open);

  // R6
  p_orphan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    orphan_drop && !out_valid |=> !out_valid);

  // R10
  p_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stray_end && !out_valid |=> !out_valid);

endmodule

bind evframe_packer evf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_kind   (out_kind),
  .orphan_drop(orphan_drop),
  .stray_end  (stray_end),
  .evt_open   (evt_open),
  .sat_hit    (sat_hit)
);

// File: tb/test_evframe_packer.sv
`timescale 1ns/1ps
module test_evframe_packer;

  localparam int CW   = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [11:0] in_bx = '0;
  logic [7:0]  in_evt = '0;
  logic [3:0]  in_chip = '0;
  logic [7:0]  in_status = '0;
  logic [23:0] in_addr = '0;
  logic [4:0]  in_adc = '0;
  logic        in_flag = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [1:0]  out_kind;

  always #4 clk = ~clk;

  evframe_packer #(.CNT_W(CW)) i_evframe_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_bx(in_bx), .in_evt(in_evt), .in_chip(in_chip),
    .in_status(in_status), .in_addr(in_addr), .in_adc(in_adc), .in_flag(in_flag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kind(out_kind)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0]  q_kind[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  // bench-side event model
  bit          m_open = 0;
  int          m_cnt = 0;
  logic [29:0] m_x = '0;
  logic [3:0]  m_err = '0;
  int          ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] bench_fold(input logic [29:0] x);
    logic [11:0] r = '0;
    for (int i = 0; i < 30; i++) r[i % 12] = r[i % 12] ^ x[i];
    return r;
  endfunction

  task automatic expect_word(input logic [1:0] k, input logic [31:0] d, input string tag);
    q_kind.push_back(k);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic drive(input logic [1:0] op);
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_start(input logic [11:0] bx, input logic [7:0] ev,
                          input logic [3:0] ch, input logic [7:0] st, input string tag);
    in_bx = bx; in_evt = ev; in_chip = ch; in_status = st;
    drive(2'b01);
    if (m_open) m_err[2] = 1'b1;
    m_err[1] = 1'b0;
    m_open = 1; m_cnt = 0; m_x = '0;
    expect_word(2'b01, (32'(bx) << 20) | (32'(ev) << 12) | (32'(ch) << 8) | 32'(st), tag);
  endtask

  task automatic do_hit(input logic [23:0] a, input logic [4:0] adc, input logic f);
    logic [29:0] w;
    in_addr = a; in_adc = adc; in_flag = f;
    drive(2'b10);
    w = (30'(a) << 6) | (30'(adc) << 1) | 30'(f);
    if (m_open) begin
      m_x = m_x ^ w;
      if (m_cnt == MAXC) m_err[1] = 1'b1;
      else m_cnt++;
      expect_word(2'b10, 32'(w), "R2");
    end else begin
      m_err[0] = 1'b1;
    end
  endtask

  task automatic do_end(input string tag);
    drive(2'b11);
    if (m_open) begin
      expect_word(2'b11, (32'(m_cnt) << 16) | (32'(bench_fold(m_x)) << 4) | 32'(m_err), tag);
      m_open = 0; m_err = '0; m_cnt = 0; m_x = '0;
    end else begin
      m_err[3] = 1'b1;
    end
  endtask

  // consumer ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ready_mode == 0) out_ready <= 1'b1;
    else out_ready <= lfsr[0] | lfsr[3];
  end

  // monitor
  bit          prev_stall = 0;
  logic [31:0] prev_data;
  logic [1:0]  prev_kind;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid && out_data == prev_data && out_kind == prev_kind,
              "R7 hold while stalled", out_data, prev_data);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_kind  = out_kind;
      if (prev_stall) check(!in_ready, "R7 in_ready low while stalled", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (q_kind.size() == 0) begin
          check(0, "R4 unexpected word", out_data, 32'hx);
        end else begin
          logic [1:0] ek;
          logic [31:0] ed;
          string et;
          ek = q_kind.pop_front();
          ed = q_data.pop_front();
          et = q_tag.pop_front();
          check(out_kind == ek, {et, " R4 kind"}, 32'(out_kind), 32'(ek));
          check(out_data == ed, et, out_data, ed);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    #1;
    check(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 32'd1);

    // R11/R6: hit straight after reset is an orphan
    do_hit(24'h123456, 5'd7, 1'b1);
    do_start(12'hABC, 8'h01, 4'h3, 8'h5A, "R1");
    do_hit(24'h000001, 5'd1, 1'b0);
    do_hit(24'hFFFFFF, 5'd31, 1'b1);
    do_hit(24'h800000, 5'd16, 1'b0);
    do_end("R6 R3 orphan flag in trailer");

    // R5/R12: empty event, flags cleared
    do_start(12'h001, 8'h02, 4'hF, 8'h00, "R1");
    do_end("R5 R12 empty event");

    // R4: no-op command consumed silently
    drive(2'b00);

    // R7: backpressure
    ready_mode = 1;
    do_start(12'hFFF, 8'hFF, 4'h0, 8'hFF, "R1");
    for (int i = 0; i < 6; i++) do_hit(24'(i * 24'h0A0B0C + 5), 5'(i * 3), 1'(i));
    do_end("R7 R3 trailer under stall");

    // R8: saturation
    do_start(12'h010, 8'h03, 4'h1, 8'h11, "R1");
    for (int i = 0; i < MAXC + 2; i++) do_hit(24'(i * 24'h013579), 5'(i), 1'(i >> 1));
    do_end("R8 saturation");

    // R9: reopen
    do_start(12'h020, 8'h04, 4'h2, 8'h22, "R1");
    do_hit(24'h00ABCD, 5'd2, 1'b0);
    do_hit(24'h00DCBA, 5'd3, 1'b1);
    do_start(12'h021, 8'h05, 4'h2, 8'h23, "R9 new header");
    do_hit(24'h0F0F0F, 5'd9, 1'b1);
    do_end("R9 reopen flag");

    // R10: stray end
    do_end("R10");
    do_start(12'h030, 8'h06, 4'h4, 8'h33, "R1");
    do_hit(24'h3C3C3C, 5'd21, 1'b0);
    do_end("R10 stray end flag");

    // mixed events
    ready_mode = 0;
    for (int e = 0; e < 4; e++) begin
      if (e == 2) ready_mode = 1;
      do_start(12'(e * 77), 8'(e + 10), 4'(e), 8'(e * 5), "R1");
      for (int h = 0; h < e * 2 + 1; h++) do_hit(24'(e * 4099 + h * 65537), 5'(h + e), 1'(h ^ e));
      do_end("R3 mixed event");
    end

    ready_mode = 0;
    for (int w = 0; w < 200 && q_kind.size() != 0; w++) @(posedge clk);
    repeat (4) @(negedge clk);
    check(q_kind.size() == 0, "R7 all words delivered", 32'(q_kind.size()), 32'd0);
    check(out_valid == 1'b0, "R4 no extra output", 32'(out_valid), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule